// File: doc/BRIEF.md
# Picture-Unit CPU Register Port

This block is the processor-facing register window of a tile-based picture unit. The processor sees eight byte-wide registers, selected by a 3-bit index. Five of them hold values: control, mask, scroll, video address and video data. One is a status byte that collects three event flags raised by the rendering side. The other two give access to a 256-byte object attribute store. The store keeps four bytes per sprite, in this order: Y position, tile number, attribute byte and X position. The block only stores and presents values. Rendering, video memory contents and palette lookup belong to other blocks. The control, mask, scroll, video address and video data values leave the block on plain output buses.

A shared two-state write toggle steers the scroll and video-address registers. It is an enumerated FSM with the states `TGL_FIRST` and `TGL_SECOND`:
- A write to register 5 or 6 in `TGL_FIRST` moves the FSM to `TGL_SECOND`.
- The same write in `TGL_SECOND` moves it back to `TGL_FIRST`.
- A status read forces `TGL_FIRST` from either state.

Reading the status register has side effects. It returns the flags as they were, and then clears the vblank flag and the toggle. Read data is combinational from the current state. Every side effect of a read or a write takes effect at the clock edge that ends the access.

Top module: `pic_regport`

## Requirements
- R1: After reset, `ctrl_q`, `mask_q`, `scroll_x`, `scroll_y`, `vram_addr` and `vram_data` are zero, all status flags are clear, and the toggle is in `TGL_FIRST`.
- R2: A write to index 0 loads `ctrl_q`, and a write to index 1 loads `mask_q`. Each value is visible after the edge that ends the write.
- R3: A read of index 2 returns vblank in bit 7, sprite-zero hit in bit 6 and sprite overflow in bit 5, with bits 4:0 zero.
- R4: After a status read, vblank is clear, the sprite-zero and overflow flags are unchanged, and the toggle is in `TGL_FIRST`.
- R5: A pulse on `evt_vblank_start`, `evt_sprite0_hit` or `evt_sprite_ovf` sets its flag until cleared. A pulse on `evt_vblank_end` clears all three flags. A same-cycle clear (vblank end or status read) wins over a set.
- R6: A write to index 3 loads the store pointer. A read of index 4 returns the byte at the pointer and leaves the pointer unchanged.
- R7: A write to index 4 stores the byte at the pointer and then increments the pointer, wrapping from 255 to 0.
- R8: Writes to index 6 load `vram_addr[13:8]` from data bits 5:0 in `TGL_FIRST` and `vram_addr[7:0]` in `TGL_SECOND`. Any other access leaves `vram_addr` unchanged.
- R9: Writes to index 5 load `scroll_x` in `TGL_FIRST` and `scroll_y` in `TGL_SECOND`. The toggle is shared, so an index-5 write followed by an index-6 write loads the low address byte.
- R10: A write to index 7 loads `vram_data`, and a read of index 7 returns it. Reads of indices 0, 1, 3, 5 and 6 return 0.
- R11: A byte stored at a pointer whose two low bits are 2 (the attribute byte) keeps bits 7:5 and 1:0 and stores bits 4:2 as zero.
- R12: Reads of any index other than 2 change neither the status flags nor the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not reading |
| evt_vblank_start | input | 1 | Sets the vblank flag |
| evt_sprite0_hit | input | 1 | Sets the sprite-zero flag |
| evt_sprite_ovf | input | 1 | Sets the overflow flag |
| evt_vblank_end | input | 1 | Clears all three flags |
| ctrl_q | output | 8 | Control register value |
| mask_q | output | 8 | Mask register value |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Video address |
| vram_data | output | 8 | Video data latch |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples `bus_rdata` one time step after it drives a read, with the strobe still held. Register outputs and flag or pointer changes are due one edge after the access. The bench therefore checks them at the next falling edge, or through a later read. Same-cycle conflicts between events, status reads and vblank end are driven in one strobe cycle. Their result is then read back in the following access.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        REG_CTRL    = 3'd0,
        REG_MASK    = 3'd1,
        REG_STAT    = 3'd2,
        REG_OAMADDR = 3'd3,
        REG_OAMDATA = 3'd4,
        REG_SCROLL  = 3'd5,
        REG_VADDR   = 3'd6,
        REG_VDATA   = 3'd7
    } reg_idx_e;

    typedef enum logic {
        TGL_FIRST  = 1'b0,
        TGL_SECOND = 1'b1
    } tgl_e;

    // bits kept in the attribute byte of each object entry
    localparam logic [7:0] ATTR_KEEP = 8'hE3;
    localparam int unsigned ATTR_SLOT = 2;
endpackage

// File: rtl/pic_oam.sv
module pic_oam #(
    parameter int unsigned BYTES = 256,
    parameter int unsigned AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_ld,
    input  logic          data_wr,
    input  logic [7:0]    din,
    output logic [AW-1:0] ptr,
    output logic [7:0]    dout
);
    import pic_pkg::*;

    logic [7:0]    mem [BYTES];
    logic [7:0]    store_val;
    logic [AW-1:0] ptr_nxt;

    always_comb begin
        if (ptr[1:0] == 2'(ATTR_SLOT)) store_val = din & ATTR_KEEP;
        else                           store_val = din;
    end

    always_comb begin
        ptr_nxt = ptr;
        if (ptr_ld)       ptr_nxt = din[AW-1:0];
        else if (data_wr) ptr_nxt = ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    always_ff @(posedge clk) begin
        if (data_wr && !ptr_ld) mem[ptr] <= store_val;
    end

    assign dout = mem[ptr];
endmodule

// File: rtl/pic_status.sv
module pic_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_vbl,
    input  logic set_s0,
    input  logic set_ovf,
    input  logic clr_all,
    input  logic stat_rd,
    output logic vbl,
    output logic s0,
    output logic ovf
);
    logic vbl_nxt, s0_nxt, ovf_nxt;

    always_comb begin
        vbl_nxt = vbl;
        s0_nxt  = s0;
        ovf_nxt = ovf;
        if (clr_all || stat_rd) vbl_nxt = 1'b0;
        else if (set_vbl)       vbl_nxt = 1'b1;
        if (clr_all)            s0_nxt  = 1'b0;
        else if (set_s0)        s0_nxt  = 1'b1;
        if (clr_all)            ovf_nxt = 1'b0;
        else if (set_ovf)       ovf_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbl <= 1'b0;
            s0  <= 1'b0;
            ovf <= 1'b0;
        end else begin
            vbl <= vbl_nxt;
            s0  <= s0_nxt;
            ovf <= ovf_nxt;
        end
    end
endmodule

// File: rtl/pic_latch2.sv
module pic_latch2 #(
    parameter int unsigned VA_W = 14,
    localparam int unsigned HI_W = VA_W - 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_scroll,
    input  logic            wr_vaddr,
    input  logic            stat_rd,
    input  logic [7:0]      din,
    output logic [7:0]      scroll_x,
    output logic [7:0]      scroll_y,
    output logic [VA_W-1:0] vaddr,
    output logic            second
);
    import pic_pkg::*;

    tgl_e state, state_nxt;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            TGL_FIRST: begin
                if (stat_rd)                     state_nxt = TGL_FIRST;
                else if (wr_scroll || wr_vaddr)  state_nxt = TGL_SECOND;
            end
            TGL_SECOND: begin
                if (stat_rd)                     state_nxt = TGL_FIRST;
                else if (wr_scroll || wr_vaddr)  state_nxt = TGL_FIRST;
            end
            default: state_nxt = TGL_FIRST;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TGL_FIRST;
        else        state <= state_nxt;
    end

    // outputs steered by the current state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scroll_x <= '0;
            scroll_y <= '0;
            vaddr    <= '0;
        end else begin
            unique case (state)
                TGL_FIRST: begin
                    if (wr_scroll) scroll_x <= din;
                    if (wr_vaddr)  vaddr[VA_W-1:8] <= din[HI_W-1:0];
                end
                TGL_SECOND: begin
                    if (wr_scroll) scroll_y <= din;
                    if (wr_vaddr)  vaddr[7:0] <= din;
                end
                default: ;
            endcase
        end
    end

    assign second = (state == TGL_SECOND);
endmodule

// File: rtl/pic_regport.sv
module pic_regport #(
    parameter int unsigned OAM_BYTES = 256,
    parameter int unsigned VA_W      = 14,
    localparam int unsigned OAM_AW   = $clog2(OAM_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [2:0]      bus_idx,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            evt_vblank_start,
    input  logic            evt_sprite0_hit,
    input  logic            evt_sprite_ovf,
    input  logic            evt_vblank_end,
    output logic [7:0]      ctrl_q,
    output logic [7:0]      mask_q,
    output logic [7:0]      scroll_x,
    output logic [7:0]      scroll_y,
    output logic [VA_W-1:0] vram_addr,
    output logic [7:0]      vram_data
);
    import pic_pkg::*;

    reg_idx_e          idx;
    logic              wr_any, rd_any;
    logic              stat_rd;
    logic              flag_vbl, flag_s0, flag_ovf;
    logic              tgl_second;
    logic [OAM_AW-1:0] oam_ptr;
    logic [7:0]        oam_dout;

    assign idx     = reg_idx_e'(bus_idx);
    assign wr_any  = bus_sel && bus_we;
    assign rd_any  = bus_sel && !bus_we;
    assign stat_rd = rd_any && (idx == REG_STAT);

    pic_oam #(.BYTES(OAM_BYTES), .AW(OAM_AW)) u_oam (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_ld  (wr_any && idx == REG_OAMADDR),
        .data_wr (wr_any && idx == REG_OAMDATA),
        .din     (bus_wdata),
        .ptr     (oam_ptr),
        .dout    (oam_dout)
    );

    pic_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vbl (evt_vblank_start),
        .set_s0  (evt_sprite0_hit),
        .set_ovf (evt_sprite_ovf),
        .clr_all (evt_vblank_end),
        .stat_rd (stat_rd),
        .vbl     (flag_vbl),
        .s0      (flag_s0),
        .ovf     (flag_ovf)
    );

    pic_latch2 #(.VA_W(VA_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_scroll (wr_any && idx == REG_SCROLL),
        .wr_vaddr  (wr_any && idx == REG_VADDR),
        .stat_rd   (stat_rd),
        .din       (bus_wdata),
        .scroll_x  (scroll_x),
        .scroll_y  (scroll_y),
        .vaddr     (vram_addr),
        .second    (tgl_second)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mask_q    <= '0;
            vram_data <= '0;
        end else if (wr_any) begin
            unique case (idx)
                REG_CTRL:  ctrl_q    <= bus_wdata;
                REG_MASK:  mask_q    <= bus_wdata;
                REG_VDATA: vram_data <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            unique case (idx)
                REG_STAT:    bus_rdata = {flag_vbl, flag_s0, flag_ovf, 5'b0};
                REG_OAMDATA: bus_rdata = oam_dout;
                REG_VDATA:   bus_rdata = vram_data;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pic_regport_chk.sv
module pic_regport_chk #(
    parameter int unsigned AW   = 8,
    parameter int unsigned VA_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_we,
    input logic [2:0]      bus_idx,
    input logic [7:0]      bus_wdata,
    input logic [7:0]      bus_rdata,
    input logic            evt_vblank_start,
    input logic            evt_vblank_end,
    input logic [7:0]      ctrl_q,
    input logic [VA_W-1:0] vram_addr,
    input logic            flag_vbl,
    input logic            flag_s0,
    input logic            flag_ovf,
    input logic            tgl_second,
    input logic [AW-1:0]   oam_ptr
);
    logic st_rd;
    assign st_rd = bus_sel && !bus_we && bus_idx == 3'd2;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == 3'd0) |=> ctrl_q == $past(bus_wdata)); // R2
    AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |-> bus_rdata[4:0] == 5'd0); // R3
    AST_STAT_CLR_VBL: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |=> !flag_vbl); // R4
    AST_STAT_CLR_TGL: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |=> !tgl_second); // R4
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vblank_end |=> !flag_vbl && !flag_s0 && !flag_ovf); // R5
    AST_VBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vblank_start && !evt_vblank_end && !st_rd) |=> flag_vbl); // R5
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == 3'd3) |=> oam_ptr == $past(bus_wdata[AW-1:0])); // R6
    AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_idx == 3'd4) |=> oam_ptr == AW'($past(oam_ptr) + 1'b1)); // R7
    AST_VADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_idx == 3'd6) |=> $stable(vram_addr)); // R8
    AST_RD_NO_TGL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_idx != 3'd2) |=> $stable(tgl_second)); // R12
endmodule

bind pic_regport pic_regport_chk #(.AW(OAM_AW), .VA_W(VA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (bus_sel),
    .bus_we           (bus_we),
    .bus_idx          (bus_idx),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .evt_vblank_start (evt_vblank_start),
    .evt_vblank_end   (evt_vblank_end),
    .ctrl_q           (ctrl_q),
    .vram_addr        (vram_addr),
    .flag_vbl         (flag_vbl),
    .flag_s0          (flag_s0),
    .flag_ovf         (flag_ovf),
    .tgl_second       (tgl_second),
    .oam_ptr          (oam_ptr)
);

// File: tb/pic_regport_tb.sv
module pic_regport_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ev_vs = 1'b0, ev_s0 = 1'b0, ev_ov = 1'b0, ev_ve = 1'b0;
    logic [7:0]  ctrl_q, mask_q, scroll_x, scroll_y, vram_data;
    logic [13:0] vram_addr;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pic_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_vblank_start(ev_vs), .evt_sprite0_hit(ev_s0),
        .evt_sprite_ovf(ev_ov), .evt_vblank_end(ev_ve),
        .ctrl_q(ctrl_q), .mask_q(mask_q), .scroll_x(scroll_x),
        .scroll_y(scroll_y), .vram_addr(vram_addr), .vram_data(vram_data)
    );

    // {req[3:0], we, idx[2:0], wdata[7:0], expected read[7:0]}
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {4'd6,  1'b1, 3'd3, 8'h10, 8'h00},  // R6 pointer 0x10
        {4'd7,  1'b1, 3'd4, 8'hA1, 8'h00},  // R7
        {4'd7,  1'b1, 3'd4, 8'hFF, 8'h00},  // R7
        {4'd11, 1'b1, 3'd4, 8'hFF, 8'h00},  // R11 attribute slot
        {4'd7,  1'b1, 3'd4, 8'h37, 8'h00},  // R7
        {4'd6,  1'b1, 3'd3, 8'h10, 8'h00},  // R6
        {4'd6,  0,    3'd4, 8'h00, 8'hA1},  // R6
        {4'd6,  0,    3'd4, 8'h00, 8'hA1},  // R6 read does not advance
        {4'd6,  1'b1, 3'd3, 8'h11, 8'h00},
        {4'd7,  0,    3'd4, 8'h00, 8'hFF},  // R7
        {4'd6,  1'b1, 3'd3, 8'h12, 8'h00},
        {4'd11, 0,    3'd4, 8'h00, 8'hE3},  // R11
        {4'd6,  1'b1, 3'd3, 8'h13, 8'h00},
        {4'd7,  0,    3'd4, 8'h00, 8'h37},  // R7
        {4'd10, 1'b1, 3'd7, 8'h5A, 8'h00},  // R10
        {4'd10, 0,    3'd7, 8'h00, 8'h5A},  // R10
        {4'd10, 0,    3'd0, 8'h00, 8'h00},  // R10 write-only reads zero
        {4'd10, 0,    3'd5, 8'h00, 8'h00}   // R10
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [7:0] exp, input int req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_idx = idx;
        #1 chk(req, {8'h0, bus_rdata}, {8'h0, exp});
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic vs, input logic s0, input logic ov, input logic ve);
        @(negedge clk);
        ev_vs = vs; ev_s0 = s0; ev_ov = ov; ev_ve = ve;
        @(negedge clk);
        ev_vs = 0; ev_s0 = 0; ev_ov = 0; ev_ve = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(1, {8'h0, ctrl_q}, 16'h0);
        chk(1, {8'h0, mask_q}, 16'h0);
        chk(1, {scroll_x, scroll_y}, 16'h0);
        chk(1, {2'b0, vram_addr}, 16'h0);
        chk(1, {8'h0, vram_data}, 16'h0);
        rd(3'd2, 8'h00, 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else            rd(VEC[i][18:16], VEC[i][7:0], int'(VEC[i][23:20]));
        end

        // R2
        wr(3'd0, 8'h80); chk(2, {8'h0, ctrl_q}, 16'h0080);
        wr(3'd1, 8'h1E); chk(2, {8'h0, mask_q}, 16'h001E);

        // R3, R4 status format and side effects
        pulse(1, 1, 1, 0);
        rd(3'd2, 8'hE0, 3);
        rd(3'd2, 8'h60, 4);

        // R8 two-write address, with high bits masked
        wr(3'd6, 8'hFF); chk(8, {2'b0, vram_addr}, 16'h3F00);
        rd(3'd2, 8'h60, 4);               // R4 toggle back to first
        wr(3'd6, 8'h21); chk(4, {2'b0, vram_addr}, 16'h2100);
        wr(3'd6, 8'h08); chk(8, {2'b0, vram_addr}, 16'h2108);

        // R9 scroll pair and shared toggle
        wr(3'd5, 8'h11); chk(9, {8'h0, scroll_x}, 16'h0011);
        wr(3'd5, 8'h22); chk(9, {8'h0, scroll_y}, 16'h0022);
        wr(3'd5, 8'h33); chk(9, {scroll_x, scroll_y}, 16'h3322);
        wr(3'd6, 8'h44); chk(9, {2'b0, vram_addr}, 16'h2144);
        wr(3'd6, 8'h01); chk(8, {2'b0, vram_addr}, 16'h0144);

        // R5 end clears all flags
        pulse(0, 0, 0, 1);
        rd(3'd2, 8'h00, 5);
        // R5 set and end in the same cycle: clear wins
        pulse(1, 1, 1, 1);
        rd(3'd2, 8'h00, 5);
        // R5 vblank set during a status read: read sees old value, clear wins
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_idx = 3'd2; ev_vs = 1'b1;
        #1 chk(5, {8'h0, bus_rdata}, 16'h0000);
        @(negedge clk);
        bus_sel = 1'b0; ev_vs = 1'b0;
        rd(3'd2, 8'h00, 5);

        // R7 pointer wrap
        wr(3'd3, 8'hFF); wr(3'd4, 8'h9C); wr(3'd4, 8'h4D);
        wr(3'd3, 8'hFF); rd(3'd4, 8'h9C, 7);
        wr(3'd3, 8'h00); rd(3'd4, 8'h4D, 7);

        // R12 other reads keep flags and toggle
        pulse(1, 0, 0, 0);
        wr(3'd6, 8'h12);
        rd(3'd4, 8'h4D, 12); rd(3'd7, 8'h5A, 12); rd(3'd0, 8'h00, 12);
        wr(3'd6, 8'h34); chk(12, {2'b0, vram_addr}, 16'h1234);
        rd(3'd2, 8'h80, 12);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule